// File: doc/BRIEF.md
# I2C Serial EEPROM Target Engine

This block is the protocol engine of a two-wire serial memory. It watches filtered, clock-synchronous samples of the bus clock and data lines, finds START and STOP conditions and decodes the device-select byte. It acknowledges the transfers that are meant for it and drives the data line through an open-drain enable. Write bytes go to a separate page-buffer block as single-cycle strobes that carry the byte and its address. Read bytes come from a synchronous memory read port with one cycle of latency.

The memory size is set by one parameter, `MEM_BYTES`, which may be 256, 512, 1024 or 2048. The size decides how the three middle select bits are used. Bits above memory address bit 7 are taken from the select byte, starting at its lowest middle bit. The middle bits that remain are compared with the strap pins. The engine owns the address pointer. That pointer supports writes from an explicit address, current-address reads, random reads through a dummy write and a repeated START, and sequential reads that run across the whole memory.

Top module: `i2cee_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Bytes clocked on the bus with no preceding START are never acknowledged, and SDA is not driven for them.
- R2: The select byte is sent MSB first. Bits 7..4 must be 1010 and bit 0 is the direction (1 is read, 0 is write). Each middle bit i (bit i+1 of the byte, compared with strap_i[i]) is a compare bit when i is at least log2(MEM_BYTES)-8, and an address bit when it is lower. A matching select is acknowledged. Any other select gets NOACK, and the engine then ignores the bus until the next START.
- R3: In a write select, the middle bits that are not compared become memory address bits 8 and up, and are loaded into the pointer together with the following address byte. In a read select those bits are ignored and the read uses the pointer.
- R4: Input bits are sampled on rising SCL. SDA drive (sda_oe) is only ever switched on while SCL is low, after a falling SCL edge.
- R5: In write mode the address byte and every data byte are acknowledged. Each data byte is handed out as a one-cycle wr_valid with wr_addr equal to the pointer. After each data byte the pointer moves one on, wrapping from MEM_BYTES-1 to 0.
- R6: After a write or a read, the pointer holds the address one past the last byte transferred. A read select with no address byte returns data from that address.
- R7: An address byte that is followed by a repeated START and a read select makes the read start at the newly loaded address.
- R8: A read sends its bytes MSB first and releases SDA during the ninth clock. While the controller acknowledges, the following address is sent next, wrapping from MEM_BYTES-1 to 0.
- R9: After a NOACK from the controller, the engine releases SDA and does not drive it again until a new START. After a STOP, SDA is released.
- R10: A STOP or a repeated START at any bit position abandons the byte in progress. An incomplete write byte is not handed out, and it does not move the pointer.
- R11: After reset SDA is released, wr_valid and mem_rd_en are low, and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Filtered, synchronised SCL sample |
| sda_i | input | 1 | Filtered, synchronised SDA sample (wired bus level) |
| strap_i | input | 3 | Device strap pins, compared with middle select bits |
| sda_oe | output | 1 | Open-drain pull-down enable for SDA |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | log2(MEM_BYTES) | Memory read address |
| mem_rd_data | input | 8 | Read data, valid one cycle after mem_rd_en |
| wr_valid | output | 1 | One-cycle strobe for a received write byte |
| wr_addr | output | log2(MEM_BYTES) | Address of the write byte |
| wr_data | output | 8 | Write byte |

## Verification
The hardest cases to reach from the ports are bus conditions that cut into a byte part-way through: a STOP after only a few data bits, or a repeated START in the middle of a select byte. Only these show whether the shift state is thrown away without leaking a write strobe or moving the pointer. The bench reaches them with a partial-bit task that clocks a chosen number of bits and then issues the condition. Current-address reads afterwards bring out the pointer state. The wrap of a sequential read at the top of memory is reached directly with a random read near the last address. Randomly chosen writes and reads of varied length, checked against a bench memory model, cover the other paths.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_ADR,
    ST_ADR_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } eng_state_t;
endpackage

// File: rtl/i2cee_busdet.sv
module i2cee_busdet (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2cee_selmatch.sv
module i2cee_selmatch #(
  parameter int HI_W = 1
) (
  input  logic [6:0] sel_top,
  input  logic [2:0] strap_i,
  output logic       sel_ok,
  output logic [2:0] sel_hi
);
  logic [2:0] diff;
  logic       unused_strap;

  for (genvar i = 0; i < 3; i++) begin : g_mid
    if (i >= HI_W) begin : g_cmp
      assign diff[i]   = sel_top[i] ^ strap_i[i];
      assign sel_hi[i] = 1'b0;
    end else begin : g_adr
      assign diff[i]   = 1'b0;
      assign sel_hi[i] = sel_top[i];
    end
  end

  assign unused_strap = ^strap_i;
  assign sel_ok = (sel_top[6:3] == 4'b1010) && (diff == 3'b000);
endmodule

// File: rtl/i2cee_ptr.sv
module i2cee_ptr #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_val;
    else if (inc)  ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave #(
  parameter int MEM_BYTES = 512,
  localparam int AW       = $clog2(MEM_BYTES),
  localparam int HI_W     = AW - 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  output logic          sda_oe,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr,
  input  logic [7:0]    mem_rd_data,
  output logic          wr_valid,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);
  import i2cee_pkg::*;

  eng_state_t  state;
  logic [2:0]  cnt;
  logic        byte_full;
  logic [7:0]  shreg;
  logic [7:0]  tx;
  logic [7:0]  nxt;
  logic        sel_rd;
  logic [2:0]  hi_lat;
  logic        m_ack;
  logic        fetch_req;
  logic        rd_pend;

  logic        scl_rise, scl_fall, start_c, stop_c;
  logic        sel_ok;
  logic [2:0]  sel_hi;
  logic        ptr_load, ptr_inc;
  logic [AW-1:0] ptr;
  logic [10:0] wide_ld_unused;

  i2cee_busdet u_det (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  i2cee_selmatch #(.HI_W(HI_W)) u_sel (
    .sel_top(shreg[7:1]), .strap_i(strap_i),
    .sel_ok(sel_ok), .sel_hi(sel_hi)
  );

  assign wide_ld_unused = {hi_lat, shreg};
  assign ptr_load = (state == ST_ADR) && scl_fall && byte_full;
  assign ptr_inc  = scl_fall && (((state == ST_WR) && byte_full) ||
                                 ((state == ST_RD) && (cnt == 3'd7)));

  i2cee_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .load(ptr_load),
    .load_val(wide_ld_unused[AW-1:0]), .inc(ptr_inc), .ptr(ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      byte_full   <= 1'b0;
      shreg       <= '0;
      tx          <= '0;
      nxt         <= '0;
      sel_rd      <= 1'b0;
      hi_lat      <= '0;
      m_ack       <= 1'b0;
      fetch_req   <= 1'b0;
      rd_pend     <= 1'b0;
      sda_oe      <= 1'b0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      wr_valid    <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
    end else begin
      wr_valid  <= 1'b0;
      fetch_req <= 1'b0;
      mem_rd_en <= fetch_req;
      if (fetch_req) mem_rd_addr <= ptr;
      rd_pend <= mem_rd_en;
      if (rd_pend) nxt <= mem_rd_data;

      if (start_c) begin
        state     <= ST_SEL;
        cnt       <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_c) begin
        state     <= ST_IDLE;
        cnt       <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_SEL, ST_ADR, ST_WR: begin
            if (scl_rise && !byte_full) begin
              shreg <= {shreg[6:0], sda_i};
              cnt   <= cnt + 3'd1;
              if (cnt == 3'd7) byte_full <= 1'b1;
            end
            if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              cnt       <= '0;
              if (state == ST_SEL) begin
                if (sel_ok) begin
                  sda_oe <= 1'b1;
                  state  <= ST_SEL_ACK;
                  sel_rd <= shreg[0];
                  if (shreg[0]) fetch_req <= 1'b1;
                  else          hi_lat    <= sel_hi;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_ADR) begin
                sda_oe <= 1'b1;
                state  <= ST_ADR_ACK;
              end else begin
                sda_oe   <= 1'b1;
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= shreg;
                state    <= ST_WR_ACK;
              end
            end
          end
          ST_SEL_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (sel_rd) begin
                state  <= ST_RD;
                tx     <= nxt;
                sda_oe <= ~nxt[7];
              end else begin
                state  <= ST_ADR;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_ADR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              state  <= ST_WR;
              sda_oe <= 1'b0;
              cnt    <= '0;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe    <= 1'b0;
                state     <= ST_RD_ACK;
                fetch_req <= 1'b1;
                cnt       <= '0;
              end else begin
                cnt    <= cnt + 3'd1;
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise) m_ack <= ~sda_i;
            if (scl_fall) begin
              if (m_ack) begin
                state  <= ST_RD;
                tx     <= nxt;
                sda_oe <= ~nxt[7];
                cnt    <= '0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cee_chk.sv
module i2cee_chk (
  input logic clk,
  input logic rst,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic wr_valid,
  input logic mem_rd_en
);
  // R4
  oe_rise_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_i);

  // R9
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> !sda_oe);

  // R5
  wr_acked_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> sda_oe);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> !wr_valid);

  // R8
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
endmodule

bind i2cee_slave i2cee_chk u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .wr_valid(wr_valid), .mem_rd_en(mem_rd_en)
);

// File: tb/sim_i2cee_slave.sv
module sim_i2cee_slave;
  localparam int MB = 512;
  localparam int AW = 9;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, mem_rd_en, wr_valid;
  logic [AW-1:0] mem_rd_addr, wr_addr;
  logic [7:0] mem_rd_data, wr_data;
  wire sda_w = sda_m & ~sda_oe;

  i2cee_slave #(.MEM_BYTES(MB)) u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_w), .strap_i(STRAP),
    .sda_oe(sda_oe), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data)
  );

  int checks = 0, fails = 0, wr_cnt = 0, r4_viol = 0, exp_ptr = 0;
  logic [7:0] exp_mem [MB];
  logic [7:0] mem_m [MB];
  logic oe_prev = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MB; i++) mem_m[i] <= 8'(i * 37 + 11);
      mem_rd_data <= '0;
    end else begin
      if (wr_valid) mem_m[wr_addr] <= wr_data;
      if (mem_rd_en) mem_rd_data <= mem_m[mem_rd_addr];
    end
  end

  always @(posedge clk) if (!rst && wr_valid) wr_cnt++;

  always @(negedge clk) begin
    if (!rst && scl_m && sda_oe && !oe_prev) r4_viol++;
    oe_prev = sda_oe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] sel(int hi, bit rd, logic [1:0] st = STRAP[2:1]);
    return {4'b1010, st, 1'(hi), rd};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4); scl_m = 1'b0; tick(3);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(3); scl_m = 1'b1; tick(4); sda_m = 1'b1; tick(4);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; tick(3); scl_m = 1'b1; tick(5); scl_m = 1'b0; tick(2);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; tick(3); scl_m = 1'b1; tick(3);
    ack = ~sda_w; tick(2); scl_m = 1'b0; tick(2);
  endtask

  task automatic recv_byte(bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(3); scl_m = 1'b1; tick(3); b = {b[6:0], sda_w}; tick(2); scl_m = 1'b0; tick(2);
    end
    sda_m = give_ack ? 1'b0 : 1'b1;
    tick(3); scl_m = 1'b1; tick(5); scl_m = 1'b0; tick(2); sda_m = 1'b1;
  endtask

  task automatic read_bytes(int n, string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      chk(b == exp_mem[exp_ptr], req, b, exp_mem[exp_ptr]);
      exp_ptr = (exp_ptr + 1) % MB;
    end
  endtask

  task automatic do_write(int a, int n);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte(sel(a >> 8, 1'b0), ack); chk(ack, "R2 write select ack", ack, 1);
    send_byte(8'(a), ack);             chk(ack, "R5 address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, "R5 data ack", ack, 1);
      exp_mem[a] = d; a = (a + 1) % MB;
    end
    i2c_stop();
    exp_ptr = a;
  endtask

  task automatic do_read_cur(int n, int hi, string req);
    bit ack;
    i2c_start();
    send_byte(sel(hi, 1'b1), ack); chk(ack, "R2 read select ack", ack, 1);
    read_bytes(n, req);
    i2c_stop();
  endtask

  task automatic do_read_rand(int a, int n, string req);
    bit ack;
    i2c_start();
    send_byte(sel(a >> 8, 1'b0), ack); chk(ack, "R7 dummy select ack", ack, 1);
    send_byte(8'(a), ack);             chk(ack, "R7 address ack", ack, 1);
    exp_ptr = a;
    i2c_start();
    send_byte(sel(a >> 8, 1'b1), ack); chk(ack, "R7 read select ack", ack, 1);
    read_bytes(n, req);
    i2c_stop();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    bit ack;
    int w0;
    void'($urandom(1234));
    for (int i = 0; i < MB; i++) exp_mem[i] = 8'(i * 37 + 11);
    tick(6); rst = 1'b0; tick(2);

    // R11 reset state
    chk(!sda_oe && !wr_valid && !mem_rd_en, "R11 reset outputs", {sda_oe, wr_valid, mem_rd_en}, 0);

    // R1 byte without START is ignored
    send_byte(sel(0, 1'b0), ack); chk(!ack, "R1 no start no ack", ack, 0);
    i2c_stop();

    // R11 pointer starts at 0, R6 current read
    do_read_cur(2, 0, "R11 R6 current read from reset");

    // R3 R5 write with high address bit, R6 continuation
    do_write(12'h120, 4);
    do_read_cur(2, 1, "R6 current read after write");
    do_read_rand(12'h121, 2, "R7 random read");

    // R8 sequential wrap at end of memory
    do_read_rand(MB - 1, 3, "R8 sequential wrap");

    // R3 read select address bit ignored
    exp_ptr = 5;
    do_read_rand(5, 1, "R7 random read low");
    do_read_cur(1, 1, "R3 read select high bit ignored");

    // R2 mismatching selects
    i2c_start();
    send_byte(sel(0, 1'b0, 2'b01), ack); chk(!ack, "R2 strap mismatch nack", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored after nack", ack, 0);
    i2c_start();
    send_byte(8'hE2 | 8'(STRAP[2:1]) << 2, ack); chk(!ack, "R2 wrong top nibble nack", ack, 0);
    i2c_stop();

    // R9 after NOACK, no drive for further clocks
    i2c_start();
    send_byte(sel(0, 1'b1), ack); chk(ack, "R9 read select ack", ack, 1);
    read_bytes(1, "R9 single read");
    send_byte(8'hFF, ack); chk(!ack && !sda_oe, "R9 released after noack", ack, 0);
    i2c_stop();
    chk(!sda_oe, "R9 released after stop", sda_oe, 0);

    // R10 STOP mid data byte
    do_write(12'h050, 1);
    w0 = wr_cnt;
    i2c_start();
    send_byte(sel(0, 1'b0), ack);
    send_byte(8'h60, ack);
    send_bits(8'hA5, 4);
    i2c_stop();
    chk(wr_cnt == w0, "R10 partial byte not written", wr_cnt, w0);
    exp_ptr = 12'h060;
    do_read_cur(1, 0, "R10 pointer after aborted write");

    // R10 repeated START mid select byte
    i2c_start();
    send_bits(sel(0, 1'b0), 3);
    i2c_start();
    send_byte(sel(0, 1'b1), ack); chk(ack, "R10 select after abort ack", ack, 1);
    read_bytes(2, "R10 read after repeated start abort");
    i2c_stop();

    // random traffic
    for (int k = 0; k < 25; k++) begin
      int kind = int'($urandom % 3);
      int a = int'($urandom % MB);
      int n = 1 + int'($urandom % 4);
      if (kind == 0) do_write(a, n);
      else if (kind == 1) do_read_cur(n, int'($urandom % 2), "R6 random current read");
      else do_read_rand(a, n, "R8 random sequential read");
    end

    // R5 model memory matches expectation for every written byte
    tick(4);
    begin
      int bad = 0;
      for (int i = 0; i < MB; i++) if (mem_m[i] != exp_mem[i]) bad++;
      chk(bad == 0, "R5 written contents", bad, 0);
    end
    chk(r4_viol == 0, "R4 drive only while SCL low", r4_viol, 0);
    finish_run();
  end
endmodule